// File: doc/BRIEF.md
# Saturating BCD Tally with Error Display

This block keeps a two-digit decimal running total fed by a decade counter. Each time the counter's value is presented with a capture strobe, the block looks at that 4-bit digit. A digit of nine is added to the total in packed BCD, so the total steps 09, 18, 27 and onward. A digit of zero clears the total. Any other digit leaves the total unchanged. The total appears on an 8-bit port as two packed BCD digits, with the tens digit in bits 7:4 and the units digit in bits 3:0.

When an addition would take the total past 99, the port shows the error code 8'hEE and the error flag rises. The alarm output then produces a square wave of 255 full periods. Each half-period is a parameter, 16 clock cycles by default. When the alarm ends, the stored total is forced to zero and the block stays locked, still flagging the error, until reset. Strobes that arrive during the alarm or while locked are ignored.

Top module: `bcd_tally_top`

## Requirements
- R1: After reset, total_o is 8'h00, err_o is 0 and alarm_o is 0.
- R2: A strobe with cap_val equal to 4'd9 adds nine to the total in packed BCD, with tens in bits 7:4 and units in bits 3:0. Both digits always stay in the range 0 to 9.
- R3: A strobe with cap_val equal to 4'd0 clears the total to 8'h00.
- R4: A strobe with any cap_val other than 0 or 9 leaves the total unchanged. A cycle without a strobe also leaves the total unchanged.
- R5: A strobe with cap_val 9 while the total is 99 makes total_o 8'hEE and err_o 1.
- R6: Starting in the first error cycle, alarm_o is a square wave that is high for ALARM_HALF cycles and then low for ALARM_HALF cycles. It runs for exactly ALARM_PERIODS (255) periods, so the error code is shown for 2*ALARM_HALF*ALARM_PERIODS cycles.
- R7: After the last alarm period, total_o reads 8'h00, alarm_o is 0 and err_o stays 1.
- R8: Strobes are ignored during the alarm and while locked. Only reset makes the block count again.
- R9: The total shown on total_o changes in the clock cycle that follows the edge at which the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_stb | input | 1 | Capture strobe for cap_val |
| cap_val | input | 4 | BCD digit from the decade counter |
| total_o | output | 8 | Packed-BCD total, or 8'hEE while the alarm runs |
| err_o | output | 1 | Overflow seen; stays high until reset |
| alarm_o | output | 1 | Alarm square wave |

## Verification
The assertions are evaluated on every cycle. They check that both stored digits stay valid BCD, that the total holds when no strobe arrives, that a zero digit clears it, and that the alarm only sounds while the error flag is high. They also check that the alarm phase flips only when its half-period counter wraps, and that the locked state is never left. The number of alarm periods, the exact BCD sequence from 09 to 99, the length of the error window and the return to counting after reset can only be shown by the bench's scenarios. The bench runs random digit streams against a decimal model and adds directed overflow and lock cases.

// File: rtl/bcd_tally_pkg.sv
package bcd_tally_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ALARM = 2'd1,
        ST_LOCK  = 2'd2
    } tally_st_e;

    localparam logic [3:0] ADD_DIGIT   = 4'd9;
    localparam logic [3:0] CLEAR_DIGIT = 4'd0;
    localparam logic [3:0] ERR_NIBBLE  = 4'hE;
endpackage

// File: rtl/bcd_add.sv
module bcd_add #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] a_i,
    input  logic [3:0]          b_i,
    output logic [4*DIGITS-1:0] sum_o,
    output logic                ovf_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic       adj;
        logic [4:0] addend;
        assign addend = (g == 0) ? {1'b0, b_i} : 5'd0;
        assign raw    = {1'b0, a_i[4*g +: 4]} + addend + {4'd0, carry[g]};
        // decimal adjust when the digit passes nine (covers binary carry too)
        assign adj    = raw > 5'd9;
        assign sum_o[4*g +: 4] = adj ? (raw[3:0] + 4'd6) : raw[3:0];
        assign carry[g+1] = adj;
    end

    assign ovf_o = carry[DIGITS];
endmodule

// File: rtl/alarm_gen.sv
module alarm_gen #(
    parameter int HALF    = 16,
    parameter int PERIODS = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic alarm_o,
    output logic done_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int PW = (PERIODS > 1) ? $clog2(PERIODS) : 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [PW-1:0] PER_LAST  = PW'(PERIODS - 1);

    typedef struct packed {
        logic          active;
        logic          phase;
        logic [CW-1:0] half_cnt;
        logic [PW-1:0] per_cnt;
    } alarm_t;

    alarm_t al_d, al_q;
    logic   done_d;

    always_comb begin
        al_d   = al_q;
        done_d = 1'b0;
        if (start_i) begin
            al_d.active   = 1'b1;
            al_d.phase    = 1'b1;
            al_d.half_cnt = '0;
            al_d.per_cnt  = '0;
        end else if (al_q.active) begin
            if (al_q.half_cnt == HALF_LAST) begin
                al_d.half_cnt = '0;
                al_d.phase    = ~al_q.phase;
                if (!al_q.phase) begin
                    if (al_q.per_cnt == PER_LAST) begin
                        done_d      = 1'b1;
                        al_d.active = 1'b0;
                        al_d.phase  = 1'b0;
                    end else begin
                        al_d.per_cnt = al_q.per_cnt + 1'b1;
                    end
                end
            end else begin
                al_d.half_cnt = al_q.half_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    assign alarm_o = al_q.phase;
    assign done_o  = done_d;

    // R6
    half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        al_q.half_cnt <= HALF_LAST);

    // R6
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(al_q.phase) && $past(al_q.active) && !$past(start_i))
            |-> ($past(al_q.half_cnt) == HALF_LAST));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!alarm_o && !al_q.active));
endmodule

// File: rtl/bcd_tally_top.sv
module bcd_tally_top #(
    parameter int DIGITS        = 2,
    parameter int ALARM_HALF    = 16,
    parameter int ALARM_PERIODS = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_stb,
    input  logic [3:0] cap_val,
    output logic [7:0] total_o,
    output logic       err_o,
    output logic       alarm_o
);
    import bcd_tally_pkg::*;

    localparam int TW = 4 * DIGITS;
    localparam logic [TW-1:0] ERR_CODE = {DIGITS{ERR_NIBBLE}};

    typedef struct packed {
        tally_st_e     st;
        logic [TW-1:0] total;
    } tally_t;

    tally_t        tl_d, tl_q;
    logic [TW-1:0] add_sum;
    logic          add_ovf;
    logic          alarm_start;
    logic          alarm_done;

    bcd_add #(.DIGITS(DIGITS)) u_add (
        .a_i   (tl_q.total),
        .b_i   (ADD_DIGIT),
        .sum_o (add_sum),
        .ovf_o (add_ovf)
    );

    alarm_gen #(.HALF(ALARM_HALF), .PERIODS(ALARM_PERIODS)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (alarm_start),
        .alarm_o (alarm_o),
        .done_o  (alarm_done)
    );

    always_comb begin
        tl_d        = tl_q;
        alarm_start = 1'b0;
        unique case (tl_q.st)
            ST_RUN: begin
                if (cap_stb) begin
                    if (cap_val == ADD_DIGIT) begin
                        if (add_ovf) begin
                            tl_d.st     = ST_ALARM;
                            alarm_start = 1'b1;
                        end else begin
                            tl_d.total = add_sum;
                        end
                    end else if (cap_val == CLEAR_DIGIT) begin
                        tl_d.total = '0;
                    end
                end
            end
            ST_ALARM: begin
                if (alarm_done) begin
                    tl_d.st    = ST_LOCK;
                    tl_d.total = '0;
                end
            end
            ST_LOCK: begin
            end
            default: tl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tl_q <= '{st: ST_RUN, total: '0};
        else        tl_q <= tl_d;
    end

    assign total_o = 8'((tl_q.st == ST_ALARM) ? ERR_CODE : tl_q.total);
    assign err_o   = (tl_q.st != ST_RUN);

    // R2
    bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_q.total[3:0] <= 4'd9) && (tl_q.total[TW-1 -: 4] <= 4'd9));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_stb && tl_q.st == ST_RUN) |=> $stable(total_o));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && cap_val == CLEAR_DIGIT && tl_q.st == ST_RUN) |=> (total_o == 8'h00));

    // R6
    alarm_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> err_o);

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_q.st == ST_LOCK) |=> (tl_q.st == ST_LOCK && total_o == 8'h00 && err_o));
endmodule

// File: tb/sim_bcd_tally_top.sv
`timescale 1ns/1ps
module sim_bcd_tally_top;
    localparam int HALF    = 16;
    localparam int PERIODS = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_stb = 1'b0;
    logic [3:0] cap_val = 4'd0;
    logic [7:0] total_o;
    logic       err_o;
    logic       alarm_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_dec = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    bcd_tally_top #(.DIGITS(2), .ALARM_HALF(HALF), .ALARM_PERIODS(PERIODS)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_val(cap_val),
        .total_o(total_o), .err_o(err_o), .alarm_o(alarm_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic apply_rst();
        rst_n = 1'b0;
        cap_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_dec = 0;
        @(negedge clk);
    endtask

    // drive on negedge, sampled at next posedge, observed at following negedge
    task automatic strobe(input logic [3:0] v);
        cap_stb = 1'b1;
        cap_val = v;
        @(negedge clk);
        cap_stb = 1'b0;
    endtask

    task automatic model_step(input logic [3:0] v);
        if (v == 4'd9) exp_dec = exp_dec + 9;
        else if (v == 4'd0) exp_dec = 0;
    endtask

    // after overflow strobe; measures error window and alarm periods
    task automatic run_alarm(input bit poke);
        int ee_cycles = 0;
        int rises = 0;
        int high_cycles = 0;
        logic prev = 1'b0;
        check("R5 err code", total_o, 8'hEE);
        check("R5 err flag", err_o, 1);
        check("R6 alarm starts high", alarm_o, 1);
        while (total_o == 8'hEE && ee_cycles < 3 * 2 * HALF * PERIODS) begin
            if (alarm_o && !prev) rises++;
            if (alarm_o) high_cycles++;
            prev = alarm_o;
            ee_cycles++;
            if (poke && (ee_cycles % 37 == 5)) begin
                cap_stb = 1'b1;
                cap_val = (ee_cycles % 2 == 0) ? 4'd0 : 4'd9;
            end else begin
                cap_stb = 1'b0;
            end
            @(negedge clk);
        end
        cap_stb = 1'b0;
        check("R6 error window cycles", ee_cycles, 2 * HALF * PERIODS);
        check("R6 alarm periods", rises, PERIODS);
        check("R6 alarm high cycles", high_cycles, HALF * PERIODS);
        check("R7 total cleared", total_o, 8'h00);
        check("R7 alarm quiet", alarm_o, 0);
        check("R7 err held", err_o, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1 reset state
        check("R1 total", total_o, 8'h00);
        check("R1 err", err_o, 0);
        check("R1 alarm", alarm_o, 0);
        apply_rst();
        check("R1 total after release", total_o, 8'h00);

        // R2 R9 directed full sequence 09..99
        for (int i = 1; i <= 11; i++) begin
            cap_stb = 1'b1;
            cap_val = 4'd9;
            @(posedge clk);
            #1;
            check("R9 update after edge", total_o, to_bcd(9 * i));
            @(negedge clk);
            cap_stb = 1'b0;
            check("R2 sequence", total_o, to_bcd(9 * i));
            check("R2 no err", err_o, 0);
        end
        // R4 ignored digits at 99
        for (int v = 1; v <= 15; v++) begin
            if (v != 9) begin
                strobe(4'(v));
                check("R4 ignored digit", total_o, 8'h99);
            end
        end
        repeat (5) @(negedge clk);
        check("R4 idle hold", total_o, 8'h99);
        // R5 overflow with strobes poked during alarm (R8)
        strobe(4'd9);
        run_alarm(1'b1);
        // R8 locked: strobes ignored
        strobe(4'd9);
        strobe(4'd9);
        check("R8 locked total", total_o, 8'h00);
        check("R8 locked err", err_o, 1);
        strobe(4'd0);
        strobe(4'd9);
        check("R8 locked after clear try", total_o, 8'h00);

        // reset restores counting
        apply_rst();
        check("R8 reset err", err_o, 0);
        strobe(4'd9);
        check("R8 counts after reset", total_o, 8'h09);
        strobe(4'd0);
        check("R3 clear", total_o, 8'h00);

        // random mix, R2 R3 R4
        exp_dec = 0;
        for (int k = 0; k < 400; k++) begin
            logic [3:0] v;
            v = ($urandom % 2 == 0) ? 4'd9 : 4'($urandom % 16);
            if (v == 4'd9 && exp_dec == 99) v = 4'd0;
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                check("R4 random idle", total_o, to_bcd(exp_dec));
            end else begin
                strobe(v);
                model_step(v);
                check(v == 4'd0 ? "R3 random clear" :
                      (v == 4'd9 ? "R2 random add" : "R4 random ignore"),
                      total_o, to_bcd(exp_dec));
            end
        end
        check("R2 random no err", err_o, 0);

        // overflow again from random state without poking
        strobe(4'd0);
        for (int i = 0; i < 11; i++) strobe(4'd9);
        check("R2 reach 99", total_o, 8'h99);
        strobe(4'd9);
        run_alarm(1'b0);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule